// File: doc/BRIEF.md
# Second-order sinc decimating converter

This block turns a one-bit delta-sigma bitstream into finished multi-bit conversion samples that need no further scaling or filtering in software. Two integrators run in cascade on every filter clock, and a differencing step runs once per decimation period. Together they form a triangular (second-order sinc) weighting over two consecutive periods. The resolution is chosen from 7 to 14 bits. The decimation period is always a power of two, 2^(bits-1) filter clocks.

The incoming bit is shifted up before it enters the first integrator, by an amount that depends on the resolution. Because of this, a full-scale result always lands at the same bit position, and the output stage needs only one fixed rounding shift.

The bitstream comes from one of two sources. In local mode a bit is taken on every system clock. In remote mode an external modulator supplies its own clock and data pair: both are synchronized, and each rising edge of that clock counts as one filter clock. Any change of mode or resolution restarts the filter from a cleared state. Samples whose filter history is incomplete are flagged as not yet valid.

Top module: `dsm_sinc2_conv`

## Requirements
- R1: The requested resolution `res_sel` is clamped into the range 7 to 14. A value below 7 behaves as 7, and a value above 14 behaves as 14.
- R2: With resolution b, a decimation instant occurs on every 2^(b-1)-th filter clock. The first one is on the first filter clock after reset or restart. `sample_stb` is high for exactly one clock right after each decimation instant. In local mode, strobes are therefore exactly 2^(b-1) system clocks apart.
- R3: On each filter clock the integrators are updated as follows. Integrator A adds the input bit times 2^(16-b). On a decimation clock, the raw result is B minus the stored history H; then H takes the value of B, and B takes the value of A. On any other filter clock, B adds A. Each step uses the value of A from before that clock's update of A. All of this arithmetic wraps modulo 2^31.
- R4: At each decimation instant, `sample` becomes the low 15 bits of (raw + 8192) >> 14, with the addition taken modulo 2^31. A constant 1 input gives 2^b once the sample is valid. A constant 0 input gives 0.
- R5: Between strobes, `sample` keeps its value.
- R6: `sample_ok` is 0 for the first two samples after reset or restart. It is 1 for each later sample.
- R7: When the clamped resolution or the mode input differs from the value the block is running with, the block restarts on that clock edge. The integrators, the history and the period count are cleared, `sample_ok` and `sample_stb` go to 0, and `sample` is kept.
- R8: In remote mode (`ext_mode`=1), `ext_clk` and `ext_dat` are each passed through two synchronizer flops. Each rising edge of the synchronized clock is one filter clock, and it uses the synchronized data bit. `int_bit` has no effect in this mode.
- R9: During reset and right after it, `sample` is 0, `sample_stb` is 0 and `sample_ok` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_mode | input | 1 | 0: local bit on every clock, 1: remote clock/data pair |
| res_sel | input | 4 | Requested resolution in bits (clamped to 7..14) |
| int_bit | input | 1 | Local modulator bit, taken on every clock in local mode |
| ext_clk | input | 1 | Remote modulator clock (asynchronous) |
| ext_dat | input | 1 | Remote modulator data (asynchronous) |
| sample | output | 15 | Rounded conversion result |
| sample_stb | output | 1 | One-clock pulse when a new sample is presented |
| sample_ok | output | 1 | The presented sample has a complete filter history |

## Verification
Some properties are checked on every cycle, in both modes. The period counter never leaves the range set by the running resolution. A strobe never lasts more than one clock. The sample changes only together with a strobe. The valid flag can rise only together with a strobe. A restart is always followed by a quiet output, with no strobe and no valid flag.

Other behaviour can only be shown by the bench's scenarios. These cover the numeric result of the triangular weighting and its rounding, full-scale and zero codes at several resolutions, clamping of out-of-range requests, the count of two invalid samples after a restart, and the equivalence of remote-clocked data to local data. For these, the bench compares against an integer model, with an exact strobe timing check in local mode and an ordered sample queue in remote mode.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

   // width of the resolution field inside the running configuration
   localparam int unsigned CFG_BITS_W = 5;

   typedef enum logic {
      SRC_LOCAL  = 1'b0,
      SRC_REMOTE = 1'b1
   } src_e;

   typedef struct packed {
      src_e                  src;
      logic [CFG_BITS_W-1:0] bits;
   } cfg_t;

endpackage

// File: rtl/dsm_bit_source.sv
module dsm_bit_source #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic remote,
   input  logic int_bit,
   input  logic ext_clk,
   input  logic ext_dat,
   output logic tick,
   output logic bit_o
);

   logic [SYNC_STAGES-1:0] ck_sh;
   logic [SYNC_STAGES-1:0] dt_sh;
   logic                   ck_prev;
   logic                   ck_rise;

   // synchronizer chain, one flop per stage for clock and data
   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ck_sh[0] <= 1'b0;
               dt_sh[0] <= 1'b0;
            end else begin
               ck_sh[0] <= ext_clk;
               dt_sh[0] <= ext_dat;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ck_sh[g] <= 1'b0;
               dt_sh[g] <= 1'b0;
            end else begin
               ck_sh[g] <= ck_sh[g-1];
               dt_sh[g] <= dt_sh[g-1];
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ck_prev <= 1'b0;
      else        ck_prev <= ck_sh[SYNC_STAGES-1];
   end

   assign ck_rise = ck_sh[SYNC_STAGES-1] & ~ck_prev;
   assign tick    = remote ? ck_rise : 1'b1;
   assign bit_o   = remote ? dt_sh[SYNC_STAGES-1] : int_bit;

endmodule

// File: rtl/dsm_period_ctr.sv
module dsm_period_ctr #(
   parameter int unsigned CNT_W  = 13,
   parameter int unsigned BITS_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              tick,
   input  logic [BITS_W-1:0] bits,
   output logic              decim
);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] wrap_mask;

   // period is 2^(bits-1): keep the low bits-1 bits of the count
   assign wrap_mask = ~({CNT_W{1'b1}} << (bits - BITS_W'(1)));
   assign decim     = (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt <= '0;
      else if (clear) cnt <= '0;
      else if (tick)  cnt <= (cnt + CNT_W'(1)) & wrap_mask;
   end

   // R2: the count never reaches beyond the running period
   a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt & ~wrap_mask) == '0)
      else $error("period count outside running period");

endmodule

// File: rtl/dsm_sinc2_core.sv
module dsm_sinc2_core #(
   parameter int unsigned ACC_W = 31,
   parameter int unsigned SH_W  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             tick,
   input  logic             decim,
   input  logic             bit_i,
   input  logic [SH_W-1:0]  shift_amt,
   output logic             fire,
   output logic [ACC_W-1:0] result
);

   logic [ACC_W-1:0] int_a;
   logic [ACC_W-1:0] int_b;
   logic [ACC_W-1:0] hist;
   logic [ACC_W-1:0] step;

   // input bit pre-scaled so the full-scale result sits at a fixed position
   assign step   = bit_i ? (ACC_W'(1) << shift_amt) : '0;
   assign fire   = tick & decim & ~clear;
   assign result = int_b - hist;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         int_a <= '0;
         int_b <= '0;
         hist  <= '0;
      end else if (clear) begin
         int_a <= '0;
         int_b <= '0;
         hist  <= '0;
      end else if (tick) begin
         if (decim) begin
            hist  <= int_b;
            int_b <= int_a;
         end else begin
            int_b <= int_b + int_a;
         end
         int_a <= int_a + step;
      end
   end

endmodule

// File: rtl/dsm_round_out.sv
module dsm_round_out #(
   parameter int unsigned ACC_W     = 31,
   parameter int unsigned RND_SHIFT = 14,
   parameter int unsigned OUT_W     = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             fire,
   input  logic [ACC_W-1:0] result,
   output logic [OUT_W-1:0] sample,
   output logic             sample_stb,
   output logic             sample_ok
);

   localparam logic [ACC_W-1:0] HALF_LSB = ACC_W'(1) << (RND_SHIFT - 1);
   localparam int unsigned      HIST_NEED = 2;

   logic [ACC_W-1:0] biased;
   logic [1:0]       seen;

   assign biased = result + HALF_LSB;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sample     <= '0;
         sample_stb <= 1'b0;
         sample_ok  <= 1'b0;
         seen       <= '0;
      end else if (clear) begin
         sample_stb <= 1'b0;
         sample_ok  <= 1'b0;
         seen       <= '0;
      end else if (fire) begin
         sample     <= OUT_W'(biased >> RND_SHIFT);
         sample_stb <= 1'b1;
         sample_ok  <= (seen == 2'(HIST_NEED));
         if (seen != 2'(HIST_NEED)) seen <= seen + 2'd1;
      end else begin
         sample_stb <= 1'b0;
      end
   end

   // R5: the presented sample only moves together with a strobe
   a_r5_sample_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_stb |-> $stable(sample))
      else $error("sample changed without strobe");

   // R2: a strobe lasts one clock
   a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |=> !sample_stb)
      else $error("strobe longer than one clock");

   // R6: validity can only appear with a fresh sample
   a_r6_ok_rises_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sample_ok) |-> sample_stb)
      else $error("valid flag rose without a sample");

endmodule

// File: rtl/dsm_sinc2_conv.sv
module dsm_sinc2_conv
   import dsm_pkg::*;
#(
   parameter int unsigned MIN_BITS    = 7,
   parameter int unsigned MAX_BITS    = 14,
   parameter int unsigned REF_SHIFT   = 16,
   parameter int unsigned ACC_W       = 31,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned SEL_W      = $clog2(MAX_BITS + 1),
   localparam int unsigned OUT_W      = MAX_BITS + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_mode,
   input  logic [SEL_W-1:0] res_sel,
   input  logic             int_bit,
   input  logic             ext_clk,
   input  logic             ext_dat,
   output logic [OUT_W-1:0] sample,
   output logic             sample_stb,
   output logic             sample_ok
);

   localparam int unsigned CNT_W     = MAX_BITS - 1;
   localparam int unsigned SH_W      = $clog2(REF_SHIFT + 1);
   localparam int unsigned RND_SHIFT = REF_SHIFT - 2;

   // elaboration-time parameter checks
   if (MIN_BITS < 2 || MIN_BITS > MAX_BITS) begin : g_bad_range
      $error("MIN_BITS must be at least 2 and not above MAX_BITS");
   end
   if (MAX_BITS > REF_SHIFT) begin : g_bad_shift
      $error("MAX_BITS must not exceed REF_SHIFT");
   end
   if (MAX_BITS + REF_SHIFT - 2 >= ACC_W) begin : g_bad_acc
      $error("ACC_W too narrow for full-scale result");
   end
   if (RND_SHIFT + OUT_W > ACC_W) begin : g_bad_out
      $error("output slice exceeds accumulator");
   end
   if (MAX_BITS >= (1 << CFG_BITS_W)) begin : g_bad_cfg
      $error("resolution field too narrow");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("at least two synchronizer stages required");
   end

   cfg_t            cfg_now;
   cfg_t            cfg_q;
   logic            restart;
   logic            tick;
   logic            bit_s;
   logic            decim;
   logic            fire;
   logic [ACC_W-1:0] result;
   logic [SH_W-1:0]  shift_amt;

   always_comb begin
      cfg_now.src = ext_mode ? SRC_REMOTE : SRC_LOCAL;
      if (res_sel < SEL_W'(MIN_BITS))
         cfg_now.bits = CFG_BITS_W'(MIN_BITS);
      else if (res_sel > SEL_W'(MAX_BITS))
         cfg_now.bits = CFG_BITS_W'(MAX_BITS);
      else
         cfg_now.bits = CFG_BITS_W'(res_sel);
   end

   assign restart = (cfg_now != cfg_q);

   always_ff @(posedge clk) begin
      cfg_q <= cfg_now;
   end

   assign shift_amt = SH_W'(REF_SHIFT) - SH_W'(cfg_q.bits);

   dsm_bit_source #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_src (
      .clk     (clk),
      .rst_n   (rst_n),
      .remote  (cfg_q.src == SRC_REMOTE),
      .int_bit (int_bit),
      .ext_clk (ext_clk),
      .ext_dat (ext_dat),
      .tick    (tick),
      .bit_o   (bit_s)
   );

   dsm_period_ctr #(
      .CNT_W  (CNT_W),
      .BITS_W (CFG_BITS_W)
   ) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (restart),
      .tick  (tick),
      .bits  (cfg_q.bits),
      .decim (decim)
   );

   dsm_sinc2_core #(
      .ACC_W (ACC_W),
      .SH_W  (SH_W)
   ) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (restart),
      .tick      (tick),
      .decim     (decim),
      .bit_i     (bit_s),
      .shift_amt (shift_amt),
      .fire      (fire),
      .result    (result)
   );

   dsm_round_out #(
      .ACC_W     (ACC_W),
      .RND_SHIFT (RND_SHIFT),
      .OUT_W     (OUT_W)
   ) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (restart),
      .fire       (fire),
      .result     (result),
      .sample     (sample),
      .sample_stb (sample_stb),
      .sample_ok  (sample_ok)
   );

   // R7: a restart leaves the output quiet on the next clock
   a_r7_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (!sample_stb && !sample_ok))
      else $error("output active right after restart");

endmodule

// File: tb/test_dsm_sinc2_conv.sv
module test_dsm_sinc2_conv;

   localparam longint unsigned MASK31 = (64'd1 << 31) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_mode = 1'b0;
   logic [3:0]  res_sel = 4'd7;
   logic        int_bit = 1'b0;
   logic        ext_clk = 1'b0;
   logic        ext_dat = 1'b0;
   logic [14:0] sample;
   logic        sample_stb;
   logic        sample_ok;

   always #10 clk = ~clk;

   dsm_sinc2_conv i_dsm_sinc2_conv (
      .clk        (clk),
      .rst_n      (rst_n),
      .ext_mode   (ext_mode),
      .res_sel    (res_sel),
      .int_bit    (int_bit),
      .ext_clk    (ext_clk),
      .ext_dat    (ext_dat),
      .sample     (sample),
      .sample_stb (sample_stb),
      .sample_ok  (sample_ok)
   );

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit cmp_en = 1'b0;
   bit done = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   // behavioural reference model
   longint unsigned m_a, m_b, m_h;
   int  m_cnt, m_seen, m_bits;
   bit  m_ext;
   int  e_sample;
   bit  e_stb, e_ok;
   int  q_s[$];
   bit  q_ok[$];

   function automatic int clampb(input int r);
      if (r < 7) return 7;
      if (r > 14) return 14;
      return r;
   endfunction

   task automatic m_clear();
      m_a = 0; m_b = 0; m_h = 0; m_cnt = 0; m_seen = 0;
      e_stb = 1'b0; e_ok = 1'b0;
   endtask

   task automatic m_tick(input bit b);
      longint unsigned raw;
      if (m_cnt == 0) begin
         raw = (m_b - m_h) & MASK31;
         e_sample = int'((((raw + 64'd8192) & MASK31) >> 14) & 64'h7FFF);
         e_stb = 1'b1;
         e_ok = (m_seen >= 2);
         if (m_seen < 2) m_seen++;
         m_h = m_b;
         m_b = m_a;
         if (m_ext) begin
            q_s.push_back(e_sample);
            q_ok.push_back(e_ok);
         end
      end else begin
         m_b = (m_b + m_a) & MASK31;
         e_stb = 1'b0;
      end
      if (b) m_a = (m_a + (64'd1 << (16 - m_bits))) & MASK31;
      m_cnt = (m_cnt + 1) % (1 << (m_bits - 1));
   endtask

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_clear();
         m_bits = clampb(int'(res_sel));
         m_ext = ext_mode;
         e_sample = 0;
      end else if (clampb(int'(res_sel)) != m_bits || ext_mode != m_ext) begin
         m_bits = clampb(int'(res_sel));
         m_ext = ext_mode;
         m_clear();
      end else if (!m_ext) begin
         m_tick(int_bit);
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // continuous comparison against the model
   always @(negedge clk) begin
      if (cmp_en && rst_n) begin
         if (!m_ext) begin
            check(sample_stb == e_stb, "R2 strobe timing", int'(sample_stb), int'(e_stb));
            check(int'(sample) == e_sample, "R3 R4 R5 sample value", int'(sample), e_sample);
            check(sample_ok == e_ok, "R6 valid flag", int'(sample_ok), int'(e_ok));
         end else if (sample_stb) begin
            if (q_s.size() == 0) begin
               check(1'b0, "R8 unexpected remote sample", int'(sample), -1);
            end else begin
               check(int'(sample) == q_s[0], "R8 remote sample value", int'(sample), q_s[0]);
               check(sample_ok == q_ok[0], "R8 R6 remote valid flag", int'(sample_ok), int'(q_ok[0]));
               void'(q_s.pop_front());
               void'(q_ok.pop_front());
            end
         end
      end
   end

   function automatic bit next_bit(input int kind);
      case (kind)
         0: return 1'b0;
         1: return 1'b1;
         2: return cyc[0];
         default: begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            return lfsr[0];
         end
      endcase
   endfunction

   task automatic run_local(input int kind, input int ncyc);
      for (int i = 0; i < ncyc; i++) begin
         @(negedge clk);
         int_bit = next_bit(kind);
      end
   endtask

   task automatic wait_stb(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         while (!sample_stb) @(negedge clk);
      end
   endtask

   task automatic run_remote(input int kind, input int nedges);
      for (int i = 0; i < nedges; i++) begin
         bit b;
         @(negedge clk);
         b = next_bit(kind);
         ext_dat = b;
         int_bit = ~int_bit ^ lfsr[3];
         @(negedge clk);
         @(negedge clk);
         ext_clk = 1'b1;
         m_tick(b);
         @(negedge clk);
         @(negedge clk);
         @(negedge clk);
         ext_clk = 1'b0;
      end
   endtask

   initial begin
      #(20 * 190000);
      if (!done) begin
         failures++;
         $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int t0, t1, nbad;
      repeat (4) @(negedge clk);
      // R9 reset state
      check(int'(sample) == 0, "R9 reset sample", int'(sample), 0);
      check(sample_stb == 1'b0, "R9 reset strobe", int'(sample_stb), 0);
      check(sample_ok == 1'b0, "R9 reset valid", int'(sample_ok), 0);
      rst_n = 1'b1;
      @(negedge clk);
      cmp_en = 1'b1;
      check(sample_ok == 1'b0 && int'(sample) == 0, "R9 state after reset", int'(sample), 0);

      // zero input at 7 bits
      run_local(0, 64 * 4);
      check(int'(sample) == 0, "R4 zero input", int'(sample), 0);

      // full scale at 7 bits
      res_sel = 4'd7;
      run_local(1, 64 * 4 + 3);
      check(int'(sample) == 128 && sample_ok, "R4 full scale 7 bits", int'(sample), 128);

      // clamp low request to 7 bits, measure strobe spacing
      res_sel = 4'd2;
      wait_stb(2); t0 = cyc;
      wait_stb(1); t1 = cyc;
      check(t1 - t0 == 64, "R1 low clamp period", t1 - t0, 64);
      check(int'(sample) == 128, "R1 low clamp full scale", int'(sample), 128);

      // half density at 10 bits
      res_sel = 4'd10;
      run_local(2, 512 * 4);
      check(int'(sample) == 512, "R4 half density 10 bits", int'(sample), 512);

      // pseudo-random at 9 bits
      res_sel = 4'd9;
      run_local(3, 256 * 6);

      // restart mid-period at 8 bits: two invalid samples then valid
      res_sel = 4'd8;
      @(negedge clk);
      check(sample_ok == 1'b0 && sample_stb == 1'b0, "R7 restart quiet", int'(sample_ok), 0);
      nbad = 0;
      fork
         run_local(1, 128 * 4);
         begin
            for (int k = 0; k < 3; k++) begin
               wait_stb(1);
               if (!sample_ok) nbad++;
            end
         end
      join
      check(nbad == 2, "R6 invalid samples after restart", nbad, 2);
      check(int'(sample) == 256, "R4 full scale 8 bits", int'(sample), 256);

      // clamp high request to 14 bits, full scale and spacing
      res_sel = 4'd15;
      int_bit = 1'b1;
      wait_stb(3); t0 = cyc;
      wait_stb(1); t1 = cyc;
      check(t1 - t0 == 8192, "R1 R2 high clamp period", t1 - t0, 8192);
      check(int'(sample) == 16384 && sample_ok, "R4 full scale 14 bits", int'(sample), 16384);

      // remote clock/data pair at 7 bits, local bit toggling meanwhile
      @(negedge clk);
      res_sel = 4'd7;
      ext_mode = 1'b1;
      repeat (4) @(negedge clk);
      run_remote(1, 64 * 4);
      repeat (8) @(negedge clk);
      check(int'(sample) == 128 && sample_ok, "R8 remote full scale", int'(sample), 128);
      run_remote(3, 64 * 3);
      repeat (8) @(negedge clk);
      check(q_s.size() == 0, "R8 remote samples all seen", q_s.size(), 0);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule